// File: doc/BRIEF.md
# Two-Output PWM Action Qualifier with Continuous Force

This block turns the state of an external time-base counter into two PWM pin levels, A and B. On every time-base tick it looks at four events: counter at zero, counter at period, compare A matched while counting up, and compare B matched while counting up. Each output has its own action register. That register holds a 2-bit code per event, and the code says whether the event leaves the pin alone, drives it low, drives it high or toggles it. The time-base counter itself lives outside the block. The block receives the count value, the count direction, the zero and period event flags and a tick enable.

Software sets up the block with single-cycle register writes. Compare values are written to a shadow copy, which becomes active at a counter-zero tick. A continuous force register can hold either pin at a steady low or high level and overrides every event. A reload-mode field decides when a newly written force value takes effect: at zero, at period, at either of them, or at once. In the usual setup the zero action drives high and the compare action drives low, which gives an active-high duty equal to the compare value.

Top module: `pwm_action_qualifier`

## Requirements
- R1: After reset both pins are low, every action code and compare value is zero, no force is applied, and the reload mode is "at zero".
- R2: Action code 00 leaves the pin unchanged, 01 drives it low, 10 drives it high and 11 inverts it. A pin changes only on a clock where `tick` is high.
- R3: In an action register, bits 1:0 act on the zero event, bits 3:2 on the period event, bits 5:4 on a compare-A up match and bits 9:8 on a compare-B up match. All other bits have no effect.
- R4: A compare event for channel X happens on a tick where `cnt_up` is high and `cnt` equals the active compare value X. While counting down there is no compare event.
- R5: A write to a compare register goes to its shadow. The shadow is copied to the active compare on a tick with `evt_zero` high and is used from the following tick on.
- R6: When events coincide on one tick, the order of precedence is: force, then compare A, then compare B, then period, then zero. An event whose code is 00 gives way to the next lower event that has an action.
- R7: In the force register, bits 1:0 apply to pin A and bits 3:2 to pin B. Code 01 forces the pin low on every tick, 10 forces it high, and 00 or 11 apply no force.
- R8: Reload-mode bits 7:6 set when a written force value becomes active: 00 on a zero tick, 01 on a period tick, 10 on a zero or period tick, 11 immediately. The value becomes active on that loading tick.
- R9: With reload mode 11, a forced level appears on the pin at the first tick after the write.
- R10: `wr_sel` selects a register: 0 action A, 1 action B, 2 compare A, 3 compare B, 4 reload mode, 5 force. Codes 6 and 7 change nothing.
- R11: With the zero action set to high and the compare-A action set to low, in up-count mode with period P and compare C (0 < C <= P), pin A is high for exactly C of every P+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base tick; events are evaluated only when it is high |
| cnt | input | CNT_W | Current time-base count |
| cnt_up | input | 1 | High while the counter counts up |
| evt_zero | input | 1 | Counter is at zero |
| evt_period | input | 1 | Counter is at period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | REG_W | Write data |
| pin_a | output | 1 | PWM output A |
| pin_b | output | 1 | PWM output B |

## Verification
On every cycle the assertions check the following:
- a pin never moves without a tick;
- a forced low or high level always lands on the pin after a tick;
- the active compare values stay unchanged unless a zero tick occurs;
- with no force, a down-count tick that carries neither a zero nor a period event leaves pin A unchanged.

Some behaviours can only be shown by the bench's scenarios, checked against its reference model. These are:
- the decoding of each action field position;
- the precedence among coinciding events;
- the loading point chosen by each reload mode;
- the immediate-mode latency;
- the ignored register selects;
- the measured duty.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    localparam int unsigned NCH      = 2;
    localparam int unsigned FLD_ZERO = 0;
    localparam int unsigned FLD_PRD  = 2;
    localparam int unsigned FLD_CAU  = 4;
    localparam int unsigned FLD_CBU  = 8;
    localparam int unsigned RLD_LSB  = 6;

    localparam logic [2:0] SEL_ACT_A = 3'd0;
    localparam logic [2:0] SEL_ACT_B = 3'd1;
    localparam logic [2:0] SEL_CMP_A = 3'd2;
    localparam logic [2:0] SEL_CMP_B = 3'd3;
    localparam logic [2:0] SEL_RLD   = 3'd4;
    localparam logic [2:0] SEL_FRC   = 3'd5;

    function automatic logic apply_act(input logic [1:0] code, input logic cur);
        case (act_e'(code))
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwmaq_pin.sv
module pwmaq_pin
    import pwmaq_pkg::*;
#(
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ev_zero,
    input  logic             ev_prd,
    input  logic             ev_ca,
    input  logic             ev_cb,
    input  logic [REG_W-1:0] act,
    input  logic [1:0]       frc,
    output logic             pin
);

    typedef struct packed {
        logic lvl;
    } pin_st_t;

    pin_st_t st_d, st_q;

    logic [1:0] code_zero, code_prd, code_ca, code_cb;

    always_comb begin
        code_zero = act[FLD_ZERO +: 2];
        code_prd  = act[FLD_PRD  +: 2];
        code_ca   = act[FLD_CAU  +: 2];
        code_cb   = act[FLD_CBU  +: 2];
        st_d      = st_q;
        if (tick) begin
            if (frc == ACT_LOW) begin
                st_d.lvl = 1'b0;
            end else if (frc == ACT_HIGH) begin
                st_d.lvl = 1'b1;
            end else if (ev_ca && code_ca != ACT_NONE) begin
                st_d.lvl = apply_act(code_ca, st_q.lvl);
            end else if (ev_cb && code_cb != ACT_NONE) begin
                st_d.lvl = apply_act(code_cb, st_q.lvl);
            end else if (ev_prd && code_prd != ACT_NONE) begin
                st_d.lvl = apply_act(code_prd, st_q.lvl);
            end else if (ev_zero && code_zero != ACT_NONE) begin
                st_d.lvl = apply_act(code_zero, st_q.lvl);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin = st_q.lvl;

endmodule

// File: rtl/pwmaq_regs.sv
module pwmaq_regs
    import pwmaq_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned REG_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic                            evt_zero,
    input  logic                            evt_period,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_sel,
    input  logic [REG_W-1:0]                wr_data,
    output logic [NCH-1:0][REG_W-1:0]       act_o,
    output logic [NCH-1:0][CNT_W-1:0]       cmp_o,
    output logic [2*NCH-1:0]                frc_o
);

    localparam int unsigned FRC_W = 2 * NCH;

    typedef struct packed {
        logic [NCH-1:0][REG_W-1:0] act;
        logic [NCH-1:0][CNT_W-1:0] shd;
        logic [NCH-1:0][CNT_W-1:0] cmp;
        rld_e                      mode;
        logic [FRC_W-1:0]          pend;
        logic [FRC_W-1:0]          frc;
    } reg_st_t;

    reg_st_t          st_d, st_q;
    logic             load_now;
    logic [FRC_W-1:0] frc_eff;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            RLD_ZERO:   load_now = tick && evt_zero;
            RLD_PERIOD: load_now = tick && evt_period;
            RLD_EITHER: load_now = tick && (evt_zero || evt_period);
            default:    load_now = 1'b1;
        endcase
        frc_eff  = load_now ? st_q.pend : st_q.frc;
        st_d.frc = frc_eff;
        for (int ch = 0; ch < NCH; ch++) begin
            if (tick && evt_zero) begin
                st_d.cmp[ch] = st_q.shd[ch];
            end
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_ACT_A: st_d.act[0] = wr_data;
                SEL_ACT_B: st_d.act[1] = wr_data;
                SEL_CMP_A: st_d.shd[0] = CNT_W'(wr_data);
                SEL_CMP_B: st_d.shd[1] = CNT_W'(wr_data);
                SEL_RLD:   st_d.mode   = rld_e'(wr_data[RLD_LSB +: 2]);
                SEL_FRC:   st_d.pend   = wr_data[FRC_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;
    assign cmp_o = st_q.cmp;
    assign frc_o = frc_eff;

endmodule

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier
    import pwmaq_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cnt_up,
    input  logic             evt_zero,
    input  logic             evt_period,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             pin_a,
    output logic             pin_b
);

    logic [NCH-1:0][REG_W-1:0] act_w;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    logic [2*NCH-1:0]          frc_eff;
    logic [NCH-1:0]            ev_cmp;
    logic [NCH-1:0]            pin_w;

    pwmaq_regs #(.CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .evt_zero   (evt_zero),
        .evt_period (evt_period),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .act_o      (act_w),
        .cmp_o      (cmp_act),
        .frc_o      (frc_eff)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_out
            assign ev_cmp[ch] = cnt_up && (cnt == cmp_act[ch]);

            pwmaq_pin #(.REG_W(REG_W)) u_pin (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .ev_zero (evt_zero),
                .ev_prd  (evt_period),
                .ev_ca   (ev_cmp[0]),
                .ev_cb   (ev_cmp[1]),
                .act     (act_w[ch]),
                .frc     (frc_eff[2*ch +: 2]),
                .pin     (pin_w[ch])
            );
        end
    endgenerate

    assign pin_a = pin_w[0];
    assign pin_b = pin_w[1];

endmodule

// File: rtl/pwmaq_checker.sv
module pwmaq_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cnt_up,
    input logic             evt_zero,
    input logic             evt_period,
    input logic [3:0]       frc_eff,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] cmp_b,
    input logic             pin_a,
    input logic             pin_b
);

    p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(pin_a) && $stable(pin_b)));

    p_force_low_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[1:0] == 2'b01) |=> !pin_a);

    p_force_high_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[1:0] == 2'b10) |=> pin_a);

    p_force_low_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[3:2] == 2'b01) |=> !pin_b);

    p_force_high_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[3:2] == 2'b10) |=> pin_b);

    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && evt_zero) |=> ($stable(cmp_a) && $stable(cmp_b)));

    p_down_no_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_up && !evt_zero && !evt_period && (frc_eff[1] == frc_eff[0]))
        |=> $stable(pin_a));

endmodule

bind pwm_action_qualifier pwmaq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cnt_up     (cnt_up),
    .evt_zero   (evt_zero),
    .evt_period (evt_period),
    .frc_eff    (frc_eff),
    .cmp_a      (cmp_act[0]),
    .cmp_b      (cmp_act[1]),
    .pin_a      (pin_a),
    .pin_b      (pin_b)
);

// File: tb/pwm_action_qualifier_bench.sv
module pwm_action_qualifier_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cnt = '0;
    logic        cnt_up = 1'b1;
    logic        evt_zero = 1'b0;
    logic        evt_period = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        pin_a, pin_b;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    run = 0, slow = 0, updown = 0, finished = 0;
    int    prd = 9;

    pwm_action_qualifier u_pwm_action_qualifier (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
        .evt_zero(evt_zero), .evt_period(evt_period), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pin_a(pin_a), .pin_b(pin_b)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    logic [15:0] m_act [2];
    logic [15:0] m_shd [2];
    logic [15:0] m_cmp [2];
    logic [1:0]  m_mode;
    logic [3:0]  m_pend, m_frc;
    logic        m_pin [2];

    function automatic logic do_code(input logic [1:0] c, input logic cur);
        if (c == 2'b01) return 1'b0;
        if (c == 2'b10) return 1'b1;
        if (c == 2'b11) return !cur;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_act[i] = '0; m_shd[i] = '0; m_cmp[i] = '0; m_pin[i] = 1'b0;
            end
            m_mode = '0; m_pend = '0; m_frc = '0;
        end else begin
            if (tick) begin
                bit ld;
                ld = (m_mode == 2'd3) || (m_mode == 2'd0 && evt_zero) ||
                     (m_mode == 2'd1 && evt_period) ||
                     (m_mode == 2'd2 && (evt_zero || evt_period));
                if (ld) m_frc = m_pend;
                for (int ch = 0; ch < 2; ch++) begin
                    logic [1:0] f;
                    logic [1:0] codes [4];
                    bit         hits [4];
                    f = m_frc[2*ch +: 2];
                    codes[0] = m_act[ch][5:4]; hits[0] = cnt_up && (cnt == m_cmp[0]);
                    codes[1] = m_act[ch][9:8]; hits[1] = cnt_up && (cnt == m_cmp[1]);
                    codes[2] = m_act[ch][3:2]; hits[2] = evt_period;
                    codes[3] = m_act[ch][1:0]; hits[3] = evt_zero;
                    if (f == 2'b01) m_pin[ch] = 1'b0;
                    else if (f == 2'b10) m_pin[ch] = 1'b1;
                    else begin
                        for (int k = 0; k < 4; k++) begin
                            if (hits[k] && codes[k] != 2'b00) begin
                                m_pin[ch] = do_code(codes[k], m_pin[ch]);
                                break;
                            end
                        end
                    end
                end
                if (evt_zero) begin
                    m_cmp[0] = m_shd[0]; m_cmp[1] = m_shd[1];
                end
            end else if (m_mode == 2'd3) begin
                m_frc = m_pend;
            end
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_act[0] = wr_data;
                    3'd1: m_act[1] = wr_data;
                    3'd2: m_shd[0] = wr_data;
                    3'd3: m_shd[1] = wr_data;
                    3'd4: m_mode   = wr_data[7:6];
                    3'd5: m_pend   = wr_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare on every clock, then drive the time base
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(pin_a === m_pin[0], cur_req, "pin_a vs model", int'(pin_a), int'(m_pin[0]));
            check(pin_b === m_pin[1], cur_req, "pin_b vs model", int'(pin_b), int'(m_pin[1]));
        end
        if (run) begin
            if (tick) begin
                if (!updown) begin
                    cnt    = (cnt == 16'(prd)) ? 16'd0 : cnt + 16'd1;
                    cnt_up = 1'b1;
                end else if (cnt_up) begin
                    if (cnt == 16'(prd)) begin cnt_up = 1'b0; cnt = cnt - 16'd1; end
                    else cnt = cnt + 16'd1;
                end else begin
                    if (cnt == 16'd0) begin cnt_up = 1'b1; cnt = cnt + 16'd1; end
                    else cnt = cnt - 16'd1;
                end
            end
            tick = slow ? !tick : 1'b1;
        end else begin
            tick = 1'b0;
        end
        evt_zero   = (cnt == 16'd0);
        evt_period = (cnt == 16'(prd));
    end

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pin_a) hi++;
        end
    endtask

    task automatic report;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        report();
    end

    initial begin
        int hi;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        cur_req = "R1";
        check(pin_a == 1'b0 && pin_b == 1'b0, "R1", "pins after reset",
              int'({pin_b, pin_a}), 0);

        // R11: zero high, compare-up low, up count
        cur_req = "R11";
        prd = 9;
        wr(3'd0, 16'h0012);
        wr(3'd2, 16'd5);
        wr(3'd1, 16'h010A);
        wr(3'd3, 16'd3);
        run = 1;
        wait_cyc(30);
        count_high(10, hi);
        check(hi == 5, "R11", "pin_a high ticks per period (C=5)", hi, 5);

        // R5: shadow compare loads at zero
        cur_req = "R5";
        wr(3'd2, 16'd7);
        wait_cyc(25);
        count_high(10, hi);
        check(hi == 7, "R5", "duty after shadow load (C=7)", hi, 7);

        // R3: unused bits ignored, zero toggles
        cur_req = "R3";
        wr(3'd0, 16'hFCC3);
        wait_cyc(40);

        // R4: up-down, compare toggles only on the way up
        cur_req = "R4";
        updown = 1;
        wr(3'd0, 16'h0030);
        wr(3'd2, 16'd4);
        wait_cyc(60);
        updown = 0;
        wait_cyc(20);

        // R2: slow ticks, zero high and period low
        cur_req = "R2";
        slow = 1;
        wr(3'd0, 16'h0006);
        wait_cyc(60);
        slow = 0;

        // R6: precedence
        cur_req = "R6";
        wr(3'd0, 16'h0021);
        wr(3'd2, 16'd0);
        wait_cyc(30);
        wr(3'd0, 16'h0009);
        wr(3'd2, 16'd9);
        wait_cyc(30);
        wr(3'd0, 16'h0120);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'd3);
        wait_cyc(30);

        // R7: force at zero reload
        cur_req = "R7";
        wr(3'd0, 16'h0012);
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'h0009);
        wait_cyc(30);
        check(pin_a == 1'b0 && pin_b == 1'b1, "R7", "forced A low B high",
              int'({pin_b, pin_a}), 2);
        wr(3'd5, 16'h000F);
        wait_cyc(30);

        // R8: period and either reload
        cur_req = "R8";
        wr(3'd4, 16'h0040);
        wr(3'd5, 16'h0006);
        wait_cyc(30);
        wr(3'd4, 16'h0080);
        wr(3'd5, 16'h0000);
        wait_cyc(30);

        // R9: immediate reload with slow ticks
        cur_req = "R9";
        slow = 1;
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'h00C0);
        wr(3'd5, 16'h0001);
        wait_cyc(4);
        check(pin_a == 1'b0, "R9", "pin_a forced low", int'(pin_a), 0);
        wr(3'd5, 16'h0002);
        wait_cyc(2);
        check(pin_a == 1'b1, "R9", "pin_a high within one tick", int'(pin_a), 1);

        // R10: unused selects change nothing
        cur_req = "R10";
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        wait_cyc(20);
        check(pin_a == 1'b1, "R10", "pin_a still forced high", int'(pin_a), 1);

        run = 0;
        wait_cyc(4);
        report();
    end

endmodule